// File: doc/BRIEF.md
# Two-Bank Byte Slave for Load-Switch Control

This block is a bus slave on a two-wire SMBus that knows only two transactions: a one-byte write and a one-byte read. It holds two 7-bit control registers, a normal bank and a suspend bank. Each bank holds three open-drain drive bits and four interrupt mask bits. A suspend-select pin picks which bank reaches the outputs, with no clock in the path. This lets the host switch between two power-plane setups without waiting for the bus. The top bit of each written byte picks the bank that the byte lands in.

A read returns the live levels of the three I/O pins and the thermal status. A thermal fault releases all three drivers, whatever the selected bank holds. SCL and SDA are oversampled by a fast system clock. START and STOP are found from SDA edges while SCL is high. The slave address comes from a three-level strap, captured once after reset, plus a variant offset.

Top module: `smb_bank_slave`

## Requirements
- R1: After reset both banks hold mask bits = 1111 and drive bits = 000 with the default `PCH_RST = 0` (111 when `PCH_RST = 1`). `sda_oe_o` is 0.
- R2: The own address is the strap base plus `ADDR_OFS`. The strap code `strap_i` is 00 = tied low (0100000), 01 = floating (0111100), 10 = tied high (1001000), and 11 is treated as low. It is captured in the first clock after reset, and later strap changes have no effect. On a matching address byte the slave pulls SDA low for the acknowledge bit.
- R3: On an address mismatch the slave gives no acknowledge, leaves SDA released, and ignores the rest of the transaction until the next START.
- R4: In a written byte, bit 7 = 1 selects the normal bank. Bit 6 is the START-STOP mask, bits 5:3 are the masks for I/O3..I/O1, and bits 2:0 are the drive bits for I/O3..I/O1. A drive bit of 0 pulls the pin low.
- R5: A written byte with bit 7 = 0 goes to the suspend bank. `susp_sel_i` low presents the suspend bank on `drive_o`/`mask_o` and high presents the normal bank, combinationally.
- R6: A START or STOP that arrives before all 8 data bits of a write discards the write. Neither bank changes.
- R7: Written data takes effect at the SCL rising edge of the data acknowledge bit, before the STOP.
- R8: A read returns bits 7:4 = 0, bit 3 = `therm_i`, and bits 2:0 = `pin_lvl_i` (I/O3..I/O1). The pin levels are sampled at the SCL falling edge that ends the address acknowledge.
- R9: While `therm_i` is 1, all `drive_o` bits are 1 (released), whatever the bank contents.
- R10: The slave acknowledges the data byte of a write to its own address.
- R11: After the read byte the slave releases SDA for the master's not-acknowledge, and it releases SDA on any STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Address strap code (00 low, 01 floating, 10 high) |
| susp_sel_i | input | 1 | 0 selects suspend bank, 1 selects normal bank |
| pin_lvl_i | input | NIO | Live I/O pin levels, bit 0 = I/O1 |
| therm_i | input | 1 | Thermal shutdown status |
| drive_o | output | NIO | Per-pin drive bit: 0 pulls low, 1 releases |
| mask_o | output | NIO+1 | Mask bits of selected bank: bit 3 START-STOP, bits 2:0 I/O3..I/O1 |

## Verification
Writes are sent with bit 7 set and with bit 7 clear, and the suspend select is toggled between them. This shows that the bank choice and the output mux work on their own. Writes cut short by a STOP or by a repeated START, set against complete writes, show that discard differs from commit. Outputs are checked before the STOP to pin down when a write takes effect. Reads with different pin patterns, with and without a thermal fault, separate the live pin sampling from the status bit. Addressing is tried with the matching address, a near miss, a strap changed after reset, and a second reset with a different strap.

// File: rtl/smb_bank_pkg.sv
package smb_bank_pkg;
  typedef enum logic [1:0] {
    STRAP_LO  = 2'b00,
    STRAP_FLT = 2'b01,
    STRAP_HI  = 2'b10
  } strap_e;

  localparam logic [6:0] BASE_LO  = 7'b0100000;
  localparam logic [6:0] BASE_FLT = 7'b0111100;
  localparam logic [6:0] BASE_HI  = 7'b1001000;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_DONE
  } bus_st_e;

  function automatic logic [6:0] strap_base(input logic [1:0] code);
    case (code)
      STRAP_FLT: strap_base = BASE_FLT;
      STRAP_HI:  strap_base = BASE_HI;
      default:   strap_base = BASE_LO;
    endcase
  endfunction
endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      scl_p     <= scl_ff[SYNC_STAGES-1];
      sda_p     <= sda_ff[SYNC_STAGES-1];
    end
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_ff[i] <= 1'b1;
        sda_ff[i] <= 1'b1;
      end else begin
        scl_ff[i] <= scl_ff[i-1];
        sda_ff[i] <= sda_ff[i-1];
      end
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
  import smb_bank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic              rw_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
      rw_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else if (start_i) begin
      st_q  <= S_ADDR;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_i) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      case (st_q)
        S_ADDR, S_WDAT: begin
          if (scl_rise_i) begin
            rx_q  <= {rx_q[DATA_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_W'(DATA_W)) begin
            if (st_q == S_WDAT) begin
              st_q <= S_WACK;
              oe_q <= 1'b1;
            end else if (rx_q[DATA_W-1:1] == own_addr_i) begin
              st_q <= S_AACK;
              oe_q <= 1'b1;
              rw_q <= rx_q[0];
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall_i) begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q <= rd_byte_i;
            oe_q <= ~rd_byte_i[DATA_W-1];
            st_q <= S_RDAT;
          end else begin
            oe_q <= 1'b0;
            st_q <= S_WDAT;
          end
        end
        S_WACK: if (scl_fall_i) begin
          oe_q <= 1'b0;
          st_q <= S_DONE;
        end
        S_RDAT: if (scl_fall_i) begin
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            oe_q <= 1'b0;
            st_q <= S_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            oe_q  <= ~tx_q[DATA_W-2];
          end
        end
        default: ;
      endcase
    end
  end

  // commit at the rising edge of the data acknowledge clock
  assign wr_stb_o  = (st_q == S_WACK) & scl_rise_i;
  assign wr_data_o = rx_q;
  assign sda_oe_o  = oe_q;
endmodule

// File: rtl/smb_bank_regs.sv
module smb_bank_regs #(
  parameter int NIO     = 3,
  parameter bit PCH_RST = 1'b0,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              susp_sel_i,
  input  logic              therm_i,
  output logic [NIO-1:0]    drive_o,
  output logic [NIO:0]      mask_o
);
  localparam int REG_W = DATA_W - 1;
  localparam logic [REG_W-1:0] RST_VAL = {{(NIO+1){1'b1}}, {NIO{PCH_RST}}};

  logic [1:0][REG_W-1:0] bank_q;  // [0] suspend, [1] normal
  logic [REG_W-1:0]      sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= {RST_VAL, RST_VAL};
    end else if (wr_stb_i) begin
      for (int b = 0; b < 2; b++)
        if (wr_data_i[DATA_W-1] == 1'(b)) bank_q[b] <= wr_data_i[REG_W-1:0];
    end
  end

  assign sel    = susp_sel_i ? bank_q[1] : bank_q[0];
  assign mask_o = sel[REG_W-1:NIO];

  for (genvar i = 0; i < NIO; i++) begin : g_drv
    assign drive_o[i] = sel[i] | therm_i;
  end
endmodule

// File: rtl/smb_bank_slave.sv
module smb_bank_slave
  import smb_bank_pkg::*;
#(
  parameter int NIO         = 3,
  parameter int ADDR_OFS    = 0,
  parameter bit PCH_RST     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe_o,
  input  logic [1:0]     strap_i,
  input  logic           susp_sel_i,
  input  logic [NIO-1:0] pin_lvl_i,
  input  logic           therm_i,
  output logic [NIO-1:0] drive_o,
  output logic [NIO:0]   mask_o
);
  localparam int DATA_W = 2 * NIO + 2;
  localparam int ADDR_W = DATA_W - 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr_q;
  logic addr_vld_q;
  logic wr_stb;
  logic [DATA_W-1:0] wr_data, rd_byte;

  smb_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  // strap taken once, first clock out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_addr_q <= '0;
      addr_vld_q <= 1'b0;
    end else if (!addr_vld_q) begin
      own_addr_q <= ADDR_W'(strap_base(strap_i)) + ADDR_W'(ADDR_OFS);
      addr_vld_q <= 1'b1;
    end
  end

  assign rd_byte = {{(DATA_W-NIO-1){1'b0}}, therm_i, pin_lvl_i};

  smb_byte_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .own_addr_i(own_addr_q), .rd_byte_i(rd_byte),
    .sda_oe_o, .wr_stb_o(wr_stb), .wr_data_o(wr_data)
  );

  smb_bank_regs #(.NIO(NIO), .PCH_RST(PCH_RST), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .wr_data_i(wr_data),
    .susp_sel_i, .therm_i,
    .drive_o, .mask_o
  );
endmodule

// File: rtl/smb_bank_chk.sv
module smb_bank_chk #(
  parameter int NIO = 3,
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              sda_s,
  input logic              scl_fall,
  input logic              stop_det,
  input logic              wr_stb,
  input logic              sda_oe_o,
  input logic              therm_i,
  input logic [NIO-1:0]    drive_o,
  input logic              addr_vld_q,
  input logic [ADDR_W-1:0] own_addr_q
);
  // acknowledge / data drive starts only after an SCL fall
  assert_drive_after_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  assert_drive_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  assert_strap_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_q && $past(addr_vld_q)) |-> $stable(own_addr_q));

  assert_release_on_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // commit lands while our acknowledge holds the line low
  assert_commit_in_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |-> (!sda_s && sda_oe_o));

  assert_therm_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_i |-> (drive_o == {NIO{1'b1}}));
endmodule

bind smb_bank_slave smb_bank_chk #(.NIO(NIO), .ADDR_W(ADDR_W)) chk_i (
  .clk_i, .rst_ni, .scl_s, .sda_s, .scl_fall, .stop_det, .wr_stb,
  .sda_oe_o, .therm_i, .drive_o, .addr_vld_q, .own_addr_q
);

// File: tb/smb_bank_slave_tb.sv
module smb_bank_slave_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic susp = 1'b1;
  logic [2:0] pins = 3'b000;
  logic therm = 1'b0;
  logic sda_oe;
  logic [2:0] drive;
  logic [3:0] mask;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smb_bank_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .susp_sel_i(susp),
    .pin_lvl_i(pins), .therm_i(therm), .drive_o(drive), .mask_o(mask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] s);
    strap = s;
    rst_n = 1'b0;
    wq();
    rst_n = 1'b1;
    wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    b = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic l;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(l);
    ack = ~l;
  endtask

  task automatic recv_byte(output logic [7:0] d, output logic nack_line);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    get_bit(nack_line);  // master does not acknowledge
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, output logic a_ack, output logic d_ack);
    bus_start();
    send_byte({a, 1'b0}, a_ack);
    send_byte(d, d_ack);
  endtask

  task automatic do_read(input logic [6:0] a, output logic a_ack, output logic [7:0] d, output logic nl);
    bus_start();
    send_byte({a, 1'b1}, a_ack);
    d = 8'h00; nl = 1'b1;
    if (a_ack) recv_byte(d, nl);
    bus_stop();
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    check("R1 drive", drive, 3'b000);
    check("R1 mask", mask, 4'b1111);
    check("R1 sda_oe", sda_oe, 1'b0);
  endtask

  task automatic t_write_normal();
    logic aa, da;
    do_write(7'h20, 8'b1_0110_101, aa, da);
    check("R2 addr ack", aa, 1'b1);
    check("R10 data ack", da, 1'b1);
    check("R7 drive before stop", drive, 3'b101);
    check("R4 mask", mask, 4'b0110);
    bus_stop();
    check("R4 drive after stop", drive, 3'b101);
  endtask

  task automatic t_write_suspend();
    logic aa, da;
    do_write(7'h20, 8'b0_1001_010, aa, da);
    bus_stop();
    check("R5 normal still shown", drive, 3'b101);
    susp = 1'b0; #1;
    check("R5 suspend drive", drive, 3'b010);
    check("R5 suspend mask", mask, 4'b1001);
    susp = 1'b1; #1;
    check("R5 back to normal", drive, 3'b101);
  endtask

  task automatic t_mismatch();
    logic aa, da;
    do_write(7'h21, 8'b1_0000_000, aa, da);
    check("R3 no addr ack", aa, 1'b0);
    check("R3 no data ack", da, 1'b0);
    bus_stop();
    check("R3 drive unchanged", drive, 3'b101);
    check("R3 mask unchanged", mask, 4'b0110);
  endtask

  task automatic t_discard();
    logic aa, da;
    bus_start();
    send_byte({7'h20, 1'b0}, aa);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    bus_stop();
    check("R6 stop mid byte", drive, 3'b101);
    bus_start();
    send_byte({7'h20, 1'b0}, aa);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_start();
    check("R6 restart mid byte", drive, 3'b101);
    send_byte({7'h20, 1'b0}, aa);
    send_byte(8'b1_1111_011, da);
    bus_stop();
    check("R6 write after restart", drive, 3'b011);
    check("R4 mask all set", mask, 4'b1111);
  endtask

  task automatic t_read();
    logic aa, nl;
    logic [7:0] d;
    pins = 3'b101;
    do_read(7'h20, aa, d, nl);
    check("R8 read ack", aa, 1'b1);
    check("R8 read pins 101", d, 8'h05);
    check("R11 released for nack", nl, 1'b1);
    check("R11 sda free after stop", sda_oe, 1'b0);
    pins = 3'b010;
    do_read(7'h20, aa, d, nl);
    check("R8 read pins 010", d, 8'h02);
  endtask

  task automatic t_thermal();
    logic aa, nl;
    logic [7:0] d;
    therm = 1'b1; #1;
    check("R9 forced off", drive, 3'b111);
    do_read(7'h20, aa, d, nl);
    check("R8 thermal bit", d, 8'h0A);
    therm = 1'b0; #1;
    check("R9 bank restored", drive, 3'b011);
  endtask

  task automatic t_strap();
    logic aa, nl;
    logic [7:0] d;
    strap = 2'b10; wq();
    do_read(7'h48, aa, d, nl);
    check("R2 late strap ignored", aa, 1'b0);
    do_read(7'h20, aa, d, nl);
    check("R2 reset address kept", aa, 1'b1);
    do_reset(2'b01);
    check("R1 drive after reset", drive, 3'b000);
    do_read(7'h3C, aa, d, nl);
    check("R2 floating strap address", aa, 1'b1);
    do_read(7'h20, aa, d, nl);
    check("R2 old address dropped", aa, 1'b0);
  endtask

  initial begin
    t_reset();
    t_write_normal();
    t_write_suspend();
    t_mismatch();
    t_discard();
    t_read();
    t_thermal();
    t_strap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule